// File: doc/BRIEF.md
# Bus-Loadable Up/Down Address Counter

This block keeps a 16-bit address count for a small bus-based datapath. A control sequencer steps it forward or backward, clears it, or writes a new value into it from the shared bidirectional data bus. A jump or branch target computed elsewhere can therefore be placed in the counter in a single cycle. The counter can also put its own value on that bus through a tri-state path with its own enable.

The count is always present on a separate address output, whatever the bus is doing, so memory addressing never waits on bus traffic. When a step carries the count past the top of its range or borrows it past the bottom, the block raises a registered out-of-bounds pulse. The pulse appears in the same cycle as the wrapped value.

Top module: `addr_counter`

## Requirements
- R1: An increment command (inc high, dec low, clear and effective load low) adds one to the count at the next rising clock edge.
- R2: A decrement command (dec high, inc low, clear and effective load low) subtracts one from the count at the next rising clock edge.
- R3: clear is synchronous. It sets the count to 0x0000 at the next edge, overrides load, inc and dec, and never raises outOfBounds.
- R4: With load high and busOe low, the value on dataBus is stored at the next edge. Load overrides inc and dec and never raises outOfBounds.
- R5: When inc and dec are high together and neither clear nor an effective load is active, the count holds and outOfBounds stays low.
- R6: An increment from 0xFFFF gives 0x0000 and raises outOfBounds for exactly the cycle in which 0x0000 first appears on addrOut.
- R7: A decrement from 0x0000 gives 0xFFFF and raises outOfBounds for exactly the cycle in which 0xFFFF first appears on addrOut.
- R8: While busOe is high, dataBus carries the current count. While busOe is low, the block leaves dataBus undriven (high impedance).
- R9: If busOe and load are high together, the block drives the bus and ignores the load. The remaining commands (clear, inc, dec) act as though load were low.
- R10: addrOut always equals the current count, whether busOe is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear of the count to zero |
| load | input | 1 | Store the dataBus value into the count |
| inc | input | 1 | Step the count up by one |
| dec | input | 1 | Step the count down by one |
| busOe | input | 1 | Drive the count onto dataBus |
| dataBus | inout | 16 | Shared bidirectional data bus |
| addrOut | output | 16 | Permanent copy of the count |
| outOfBounds | output | 1 | One-cycle pulse on wrap in either direction |

## Verification
Two pairs of functions can land in the same cycle. The first is a bus load together with a bus drive. The bench raises load, busOe and inc at once, leaves its own bus driver off, and then expects the driven bus to show the old count and the next count to be the old count plus one, not a loaded value. The second is a wrapping step together with an overriding command. A clear or load given at the range ends, alongside inc or dec, must leave outOfBounds low, while both-step commands at the range ends must hold the count with no flag.

// File: rtl/addr_counter_pkg.sv
package addr_counter_pkg;

  // Strobes the decoder hands to the datapath; at most one of
  // clr/ld/up/down is set in any cycle.
  typedef struct packed {
    logic clr;
    logic ld;
    logic up;
    logic down;
    logic drive;
  } ctrStrobe_t;

endpackage

// File: rtl/addr_counter_ctrl.sv
module addr_counter_ctrl
  import addr_counter_pkg::*;
(
  input  logic       clear,
  input  logic       load,
  input  logic       inc,
  input  logic       dec,
  input  logic       busOe,
  output ctrStrobe_t strb
);

  logic loadOk;
  logic stepOk;

  // Bus drive wins over a load request; clear wins over everything.
  assign loadOk = load && !busOe && !clear;
  assign stepOk = !clear && !loadOk;

  always_comb begin
    strb       = '0;
    strb.clr   = clear;
    strb.ld    = loadOk;
    strb.up    = stepOk && inc && !dec;
    strb.down  = stepOk && dec && !inc;
    strb.drive = busOe;
  end

endmodule

// File: rtl/addr_counter_path.sv
module addr_counter_path
  import addr_counter_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  ctrStrobe_t       strb,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] count,
  output logic             wrapFlag
);

  localparam logic [WIDTH:0] ONE = {{WIDTH{1'b0}}, 1'b1};

  logic [WIDTH:0] upSum;
  logic [WIDTH:0] dnDiff;

  // Extra top bit catches the carry out or the borrow.
  assign upSum  = {1'b0, count} + ONE;
  assign dnDiff = {1'b0, count} - ONE;

  always_ff @(posedge clk) begin
    if (strb.clr) begin
      count    <= '0;
      wrapFlag <= 1'b0;
    end else if (strb.ld) begin
      count    <= busIn;
      wrapFlag <= 1'b0;
    end else if (strb.up) begin
      count    <= upSum[WIDTH-1:0];
      wrapFlag <= upSum[WIDTH];
    end else if (strb.down) begin
      count    <= dnDiff[WIDTH-1:0];
      wrapFlag <= dnDiff[WIDTH];
    end else begin
      wrapFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/addr_counter.sv
module addr_counter
  import addr_counter_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             load,
  input  logic             inc,
  input  logic             dec,
  input  logic             busOe,
  inout  wire  [WIDTH-1:0] dataBus,
  output logic [WIDTH-1:0] addrOut,
  output logic             outOfBounds
);

  localparam logic [WIDTH-1:0] MAXVAL = '1;

  ctrStrobe_t       strb;
  logic [WIDTH-1:0] count;
  logic             wrapFlag;

  addr_counter_ctrl u_ctrl (
    .clear (clear),
    .load  (load),
    .inc   (inc),
    .dec   (dec),
    .busOe (busOe),
    .strb  (strb)
  );

  addr_counter_path #(.WIDTH(WIDTH)) u_path (
    .clk      (clk),
    .strb     (strb),
    .busIn    (dataBus),
    .count    (count),
    .wrapFlag (wrapFlag)
  );

  assign dataBus     = strb.drive ? count : 'z;
  assign addrOut     = count;
  assign outOfBounds = wrapFlag;

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    clear |=> (addrOut == '0) && !outOfBounds); // R3

  AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (clear)
    (load && !busOe) |=> (addrOut == $past(dataBus)) && !outOfBounds); // R4

  AST_BOTH_STEPS_HOLD: assert property (@(posedge clk) disable iff (clear)
    (inc && dec && !(load && !busOe)) |=> $stable(addrOut) && !outOfBounds); // R5

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (clear)
    (inc && !dec && !(load && !busOe) && addrOut == MAXVAL)
      |=> (addrOut == '0) && outOfBounds); // R6

  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (clear)
    (dec && !inc && !(load && !busOe) && addrOut == '0)
      |=> (addrOut == MAXVAL) && outOfBounds); // R7

  AST_BUS_SHOWS_COUNT: assert property (@(posedge clk)
    busOe |-> dataBus == addrOut); // R8

  AST_DRIVE_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (clear)
    (load && busOe && inc && !dec) |=> addrOut == $past(addrOut) + 1'b1); // R9

endmodule

// File: tb/addr_counter_test.sv
`timescale 1ns/1ps
module addr_counter_test;

  logic        clk = 1'b0;
  logic        clear = 1'b0, load = 1'b0, inc = 1'b0, dec = 1'b0, busOe = 1'b0;
  logic [15:0] tbBus = '0;
  logic        tbDrv = 1'b0;
  wire  [15:0] dataBus;
  logic [15:0] addrOut;
  logic        outOfBounds;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [15:0] model = '0;
  logic [15:0] expAddrQ[$];
  logic        expFlagQ[$];
  string       expTagQ[$];

  always #10 clk = ~clk;

  assign dataBus = tbDrv ? tbBus : 'z;

  addr_counter uut (
    .clk(clk), .clear(clear), .load(load), .inc(inc), .dec(dec),
    .busOe(busOe), .dataBus(dataBus), .addrOut(addrOut),
    .outOfBounds(outOfBounds)
  );

  task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of commands and pushes the expected result.
  task automatic step(bit c, bit l, bit i, bit d, bit o, logic [15:0] v, string tag);
    logic f;
    @(negedge clk);
    clear = c; load = l; inc = i; dec = d; busOe = o;
    tbBus = v; tbDrv = l && !o;
    #1;
    if (o) begin
      check16({tag, " R8 bus"}, dataBus, model);
      check16({tag, " R10 addr"}, addrOut, model);
    end
    if (c) begin model = '0; f = 1'b0; end
    else if (l && !o) begin model = v; f = 1'b0; end
    else if (i && !d) begin f = (model == 16'hFFFF); model = model + 16'd1; end
    else if (d && !i) begin f = (model == 16'h0000); model = model - 16'd1; end
    else f = 1'b0;
    expAddrQ.push_back(model);
    expFlagQ.push_back(f);
    expTagQ.push_back(tag);
  endtask

  // Monitor: compares after each edge.
  always @(posedge clk) begin
    #2;
    if (expAddrQ.size() > 0) begin
      automatic logic [15:0] ea = expAddrQ.pop_front();
      automatic logic        ef = expFlagQ.pop_front();
      automatic string       et = expTagQ.pop_front();
      check16({et, " count"}, addrOut, ea);
      check16({et, " flag"}, {15'd0, outOfBounds}, {15'd0, ef});
    end
  end

  task automatic idle();
    step(0, 0, 0, 0, 0, 16'h0, "idle");
  endtask

  initial begin
    step(1, 0, 0, 0, 0, 16'h0, "R3 reset state");
    step(0, 0, 1, 0, 0, 16'h0, "R1 inc");
    step(0, 0, 1, 0, 0, 16'h0, "R1 inc");
    step(0, 0, 1, 0, 0, 16'h0, "R1 inc");
    step(0, 0, 0, 1, 0, 16'h0, "R2 dec");
    step(0, 1, 0, 0, 0, 16'hFFFE, "R4 load");
    step(0, 0, 1, 0, 0, 16'h0, "R1 inc to top");
    step(0, 0, 1, 0, 0, 16'h0, "R6 wrap up");
    step(0, 0, 1, 0, 0, 16'h0, "R6 flag drops");
    step(0, 0, 0, 1, 0, 16'h0, "R2 dec to zero");
    step(0, 0, 0, 1, 0, 16'h0, "R7 wrap down");
    step(0, 0, 0, 1, 0, 16'h0, "R7 flag drops");
    step(0, 0, 1, 1, 0, 16'h0, "R5 both hold");
    step(0, 1, 0, 0, 0, 16'hFFFF, "R4 load top");
    step(0, 0, 1, 1, 0, 16'h0, "R5 hold at top");
    step(0, 1, 1, 0, 0, 16'h0000, "R4 load beats inc at top");
    step(0, 1, 0, 1, 0, 16'h1234, "R4 load beats dec");
    step(0, 0, 0, 0, 1, 16'h0, "R10 drive idle");
    step(0, 1, 1, 0, 1, 16'h0, "R9 drive ignores load");
    step(0, 1, 0, 0, 1, 16'h0, "R9 drive ignores load");
    step(1, 1, 1, 0, 0, 16'hFFFF, "R3 clear beats load");
    step(0, 0, 0, 1, 0, 16'h0, "R7 wrap after clear");
    step(1, 0, 1, 0, 0, 16'h0, "R3 clear beats inc at top");
    step(0, 0, 0, 0, 0, 16'h0, "R3 no flag idle");
    idle();
    idle();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule